// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer. It divides a fast input clock, which stands in for the oscillator output, by a programmable ratio. It produces one single-cycle pulse per full division. That pulse is meant for one input of a phase/frequency detector.

The ratio comes from a 17-bit control word. The word is split into an 11-bit main count M in the upper bits and a 6-bit swallow count A in the lower bits. A prescaler divides by 33 while the swallow counter is nonzero and by 32 afterwards. The main counter counts prescaler cycles. One output period therefore lasts N = 32·M + A input cycles. With this split the fast prescaler stays small while the main counter only has to run at one thirty-second of the input rate.

A word is written with a load strobe and is held as pending. It becomes active only when the current period ends, so no period is ever cut short. Words that cannot be divided exactly are flagged. The divider keeps running with clamped values.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is 0 and `bad_setting` shows the legality of the reset word (default 259: M=4, A=3, legal). The first period after reset release lasts N of the reset word (131 cycles), measured from the first rising edge after release.
- R2: For a legal word (1 ≤ M, A ≤ M, A ≤ 31, where M = word[16:6] and A = word[5:0]), consecutive output pulses are exactly 32·M + A input cycles apart.
- R3: `div_pulse` is high for exactly one input-clock cycle per period.
- R4: Within a period, the prescaler divides by 33 for the first A prescaler cycles and by 32 for the remaining M − A cycles.
- R5: A word loaded in the middle of a period does not change that period. Only the last word loaded before a boundary governs the period that follows it.
- R6: A word presented with `load` in the cycle that ends a period governs the very next period.
- R7: A word with A > M or A ≥ 32 raises `bad_setting`. It still divides, with the swallow count clamped to min(A, 31, M).
- R8: A word with M = 0 raises `bad_setting` and divides as if M were 1, with the swallow count clamped to at most 1.
- R9: `bad_setting` describes the word governing the current period. It changes only at a period boundary, in the same cycle that `div_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided (oscillator stand-in) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 17 | Ratio word: main count in [16:6], swallow count in [5:0] |
| load | input | 1 | Captures `ctrl_word` as the pending ratio |
| div_pulse | output | 1 | One-cycle pulse at each period boundary |
| bad_setting | output | 1 | High while the active word is outside the exact-division range |

## Verification
The divider is tried with several groups of words. The smallest words (M=1 with A of 0 and 1) show whether the prescaler switches modulus on the first and only prescaler cycle. Words with A equal to M and A at its ceiling of 31 test the longest stretch at divide-by-33, and words with A=0 and a large M test the plain divide-by-32 path. Random legal words check that the interval between pulses equals 32·M + A for arbitrary splits. Illegal words (A > M, A ≥ 32, M = 0) tell clamped division apart from raw division, and also check that the flag follows the active word. Loads placed mid-period, two loads in one period, and a load in the boundary cycle separate correct hand-over timing from early or late adoption of a new word.

// File: rtl/pss_pkg.sv
package pss_pkg;

   typedef enum logic {
      MOD_LOW  = 1'b0,
      MOD_HIGH = 1'b1
   } modsel_e;

   function automatic int unsigned eff_main(input int unsigned m);
      return (m == 0) ? 1 : m;
   endfunction

   function automatic int unsigned eff_swallow(input int unsigned a,
                                               input int unsigned m,
                                               input int unsigned pre_log2);
      int unsigned cap;
      int unsigned ac;
      int unsigned me;
      cap = (1 << pre_log2) - 1;
      ac  = (a > cap) ? cap : a;
      me  = eff_main(m);
      return (ac > me) ? me : ac;
   endfunction

   function automatic bit bad_word(input int unsigned a,
                                   input int unsigned m,
                                   input int unsigned pre_log2);
      return (m == 0) || (a > m) || (a > ((1 << pre_log2) - 1));
   endfunction

endpackage

// File: rtl/pss_prescale.sv
module pss_prescale
   import pss_pkg::*;
#(
   parameter int unsigned PRE_LOG2 = 5
) (
   input  logic    clk,
   input  logic    rst_n,
   input  modsel_e mode,
   output logic    tick
);
   localparam int unsigned PC_W = PRE_LOG2 + 1;
   localparam logic [PC_W-1:0] LOW_LAST  = PC_W'((1 << PRE_LOG2) - 1);
   localparam logic [PC_W-1:0] HIGH_LAST = PC_W'(1 << PRE_LOG2);

   logic [PC_W-1:0] pc_q;

   assign tick = (mode == MOD_HIGH) ? (pc_q == HIGH_LAST) : (pc_q == LOW_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pc_q <= '0;
      else if (tick) pc_q <= '0;
      else           pc_q <= pc_q + 1'b1;
   end

   // R4
   prescale_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_q == LOW_LAST && mode == MOD_HIGH) |=> (pc_q == HIGH_LAST));
   // R4
   prescale_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_q == LOW_LAST && mode == MOD_LOW) |=> (pc_q == '0));
   // R4
   prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q <= HIGH_LAST);

endmodule

// File: rtl/pss_count.sv
module pss_count
   import pss_pkg::*;
#(
   parameter int unsigned M_W    = 11,
   parameter int unsigned A_W    = 6,
   parameter int unsigned M_INIT = 4,
   parameter int unsigned A_INIT = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [M_W-1:0] m_next,
   input  logic [A_W-1:0] a_next,
   output modsel_e        mode,
   output logic           boundary
);
   logic [M_W-1:0] m_left;
   logic [A_W-1:0] a_left;

   assign mode     = (a_left != '0) ? MOD_HIGH : MOD_LOW;
   assign boundary = tick && (m_left == M_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_left <= M_W'(M_INIT);
         a_left <= A_W'(A_INIT);
      end else if (tick) begin
         if (boundary) begin
            m_left <= m_next;
            a_left <= a_next;
         end else begin
            m_left <= m_left - 1'b1;
            if (a_left != '0) a_left <= a_left - 1'b1;
         end
      end
   end

   // R4
   swallow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      M_W'(a_left) <= m_left);
   // R8
   main_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_left != '0);
   // R4
   swallow_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !boundary && a_left != '0) |=> (a_left == $past(a_left) - 1'b1));

endmodule

// File: rtl/pss_word_hold.sv
module pss_word_hold
   import pss_pkg::*;
#(
   parameter int unsigned M_W      = 11,
   parameter int unsigned A_W      = 6,
   parameter int unsigned PRE_LOG2 = 5,
   parameter int unsigned RST_WORD = 259
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [M_W+A_W-1:0] ctrl_word,
   input  logic               boundary,
   output logic [M_W-1:0]     m_next,
   output logic [A_W-1:0]     a_next,
   output logic [M_W+A_W-1:0] act_word,
   output logic               bad_q
);
   localparam int unsigned W        = M_W + A_W;
   localparam int unsigned RST_M    = RST_WORD >> A_W;
   localparam int unsigned RST_A    = RST_WORD & ((1 << A_W) - 1);
   localparam bit          BAD_INIT = bad_word(RST_A, RST_M, PRE_LOG2);

   logic [W-1:0]   pend_q;
   logic [W-1:0]   sel;
   logic [M_W-1:0] m_raw;
   logic [A_W-1:0] a_raw;
   logic           bad_next;

   assign sel      = load ? ctrl_word : pend_q;
   assign m_raw    = sel[W-1:A_W];
   assign a_raw    = sel[A_W-1:0];
   assign m_next   = M_W'(eff_main(32'(m_raw)));
   assign a_next   = A_W'(eff_swallow(32'(a_raw), 32'(m_raw), PRE_LOG2));
   assign bad_next = bad_word(32'(a_raw), 32'(m_raw), PRE_LOG2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= W'(RST_WORD);
         act_word <= W'(RST_WORD);
         bad_q    <= BAD_INIT;
      end else begin
         if (load) pend_q <= ctrl_word;
         if (boundary) begin
            act_word <= sel;
            bad_q    <= bad_next;
         end
      end
   end

   // R6
   boundary_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && boundary) |=> (act_word == $past(ctrl_word)));

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
   import pss_pkg::*;
#(
   parameter int unsigned M_W      = 11,
   parameter int unsigned A_W      = 6,
   parameter int unsigned PRE_LOG2 = 5,
   parameter int unsigned RST_WORD = 259
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [M_W+A_W-1:0] ctrl_word,
   input  logic               load,
   output logic               div_pulse,
   output logic               bad_setting
);
   localparam int unsigned RST_M = RST_WORD >> A_W;
   localparam int unsigned RST_A = RST_WORD & ((1 << A_W) - 1);

   if (A_W < PRE_LOG2 + 1) begin : g_bad_aw
      $error("swallow field too narrow for the prescaler modulus");
   end
   if (M_W < A_W) begin : g_bad_mw
      $error("main field must be at least as wide as the swallow field");
   end
   if (M_W + A_W > 31) begin : g_bad_word
      $error("control word wider than supported");
   end

   logic [M_W-1:0]     m_next;
   logic [A_W-1:0]     a_next;
   logic [M_W+A_W-1:0] act_word;
   logic               tick;
   logic               boundary;
   modsel_e            mode;

   pss_word_hold #(
      .M_W(M_W), .A_W(A_W), .PRE_LOG2(PRE_LOG2), .RST_WORD(RST_WORD)
   ) u_hold (
      .clk(clk), .rst_n(rst_n), .load(load), .ctrl_word(ctrl_word),
      .boundary(boundary), .m_next(m_next), .a_next(a_next),
      .act_word(act_word), .bad_q(bad_setting)
   );

   pss_prescale #(
      .PRE_LOG2(PRE_LOG2)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick)
   );

   pss_count #(
      .M_W(M_W), .A_W(A_W),
      .M_INIT(eff_main(RST_M)),
      .A_INIT(eff_swallow(RST_A, RST_M, PRE_LOG2))
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .m_next(m_next),
      .a_next(a_next), .mode(mode), .boundary(boundary)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_pulse <= 1'b0;
      else        div_pulse <= boundary;
   end

   // R3
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);
   // R9
   flag_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bad_setting) |-> div_pulse);
   // R5
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_word) |-> div_pulse);

endmodule

// File: tb/pulse_swallow_div_test.sv
`timescale 1ns/1ps
module pulse_swallow_div_test;
   localparam int RST_WORD = 259;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [16:0] ctrl_word = '0;
   logic        div_pulse;
   logic        bad_setting;

   always #4 clk = ~clk;

   pulse_swallow_div uut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .load(load),
      .div_pulse(div_pulse), .bad_setting(bad_setting)
   );

   typedef struct {
      int n;
      bit bad;
      int tag;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad_cnt = 0;
   int   load_count = 0;
   int   used = 0;
   int   cyc = 0;
   int   last_n = 0;
   bit   prev_pulse = 1'b0;
   bit   mon_on = 1'b0;
   exp_t cur;

   function automatic exp_t expect_of(input logic [16:0] w, input int tag);
      exp_t e;
      int m, a, me, ac, ae;
      m  = int'(w[16:6]);
      a  = int'(w[5:0]);
      me = (m == 0) ? 1 : m;
      ac = (a > 31) ? 31 : a;
      ae = (ac > me) ? me : ac;
      e.n   = 32 * me + ae;
      e.bad = (m == 0) || (a > m) || (a > 31);
      e.tag = tag;
      return e;
   endfunction

   task automatic chk(input bit ok, input int tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad_cnt++;
         $display("FAIL R%0d %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // the bench's own record of which loads the design has sampled
   always @(posedge clk) if (rst_n && load) load_count <= load_count + 1;

   // monitor: compares each finished period against the scoreboard entry
   always @(negedge clk) begin
      if (mon_on) begin
         cyc++;
         if (div_pulse) begin
            // R3 single-cycle pulse
            chk(!prev_pulse, 3, "pulse width", 2, 1);
            // R1 / R2 / R5 / R6 / R7 / R8 interval of the finished period
            chk(cyc == cur.n, cur.tag, "interval", cyc, cur.n);
            cyc = 0;
            while (used < load_count) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, 5, "scoreboard empty", 0, 1);
                  used = load_count;
               end else begin
                  cur = exp_q.pop_front();
                  used++;
               end
            end
            // R9 flag follows the word of the new period (R7 / R8 when illegal)
            chk(bad_setting == cur.bad, cur.bad ? cur.tag : 9, "flag",
                int'(bad_setting), int'(cur.bad));
         end
         prev_pulse = div_pulse;
      end
   end

   task automatic wait_pulse(input int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (!div_pulse);
      end
   endtask

   task automatic drive(input logic [16:0] w, input int tag, input int offset);
      exp_t e;
      repeat (offset) @(negedge clk);
      e = expect_of(w, tag);
      ctrl_word = w;
      load = 1'b1;
      exp_q.push_back(e);
      last_n = e.n;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic apply(input int m, input int a, input int tag, input int offset);
      logic [16:0] w;
      w = {m[10:0], a[5:0]};
      drive(w, tag, offset);
      wait_pulse(2);
   endtask

   initial begin
      exp_t r;
      cur = expect_of(17'(RST_WORD), 1);
      last_n = cur.n;
      repeat (3) @(negedge clk);
      // R1 reset state
      r = expect_of(17'(RST_WORD), 1);
      chk(div_pulse == 1'b0, 1, "pulse in reset", int'(div_pulse), 0);
      chk(bad_setting == r.bad, 1, "flag in reset", int'(bad_setting), int'(r.bad));
      rst_n = 1'b1;
      #1 mon_on = 1'b1;
      // R1 first period from reset uses the reset word
      wait_pulse(1);

      // R2 directed legal words
      apply(1, 0, 2, 3);
      apply(1, 1, 2, 5);
      apply(31, 31, 2, 7);
      apply(100, 0, 2, 2);
      apply(300, 17, 2, 11);
      apply(2, 2, 2, 4);

      // R7 illegal swallow counts, clamped
      apply(3, 10, 7, 6);
      apply(50, 40, 7, 3);
      apply(20, 32, 7, 9);
      apply(40, 63, 7, 1);

      // R8 zero main count
      apply(0, 0, 8, 2);
      apply(0, 5, 8, 8);

      // R5 two loads in one period: only the second governs
      drive({11'd9, 6'd1}, 5, 3);
      drive({11'd6, 6'd5}, 5, 3);
      wait_pulse(2);

      // R6 load in the cycle that closes the period
      wait_pulse(1);
      drive({11'd12, 6'd7}, 6, last_n - 1);
      wait_pulse(2);
      wait_pulse(1);
      drive({11'd33, 6'd33}, 6, last_n - 1);
      wait_pulse(2);

      // R2 random legal words at random mid-period offsets
      for (int k = 0; k < 16; k++) begin
         int m, a;
         m = 1 + $urandom_range(39, 0);
         a = $urandom_range((m < 31) ? m : 31, 0);
         apply(m, a, 2, 1 + $urandom_range(20, 0));
      end

      // R9 legal word after an illegal one clears the flag
      apply(0, 0, 8, 2);
      apply(5, 4, 9, 2);

      $display("test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      bad_cnt++;
      total++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("test done: total=%0d bad=%0d", total, bad_cnt);
      $finish;
   end

endmodule